// File: doc/BRIEF.md
# Dual FIFO Watermark Monitor

This block serves one serial link controller. It holds two byte-wide queues, one in the transmit direction and one in the receive direction, and it watches how full each queue is. Software sets one 8-bit control register. Its low six bits pick two thresholds from a table of eight levels: a low threshold for the transmit queue and a high threshold for the receive queue.

Two live status flags report when the transmit queue has drained below its threshold and when the receive queue has filled past its threshold. Each flag follows the occupancy and never latches. A flag that is set can pull an active-low interrupt line, but only when its bit in a separate interrupt-enable register is set. Each queue has push and pop strobes, a show-ahead read data output, an occupancy count, full and empty indications, and one-cycle pulses that report a rejected push or a rejected pop.

Top module: `fifo_wmark_unit`

## Requirements
- R1: Register offset 0 (reg_addr=0) is the threshold control register and resets to 0x00. Bits 2:0 hold the receive high-threshold code and bits 5:3 hold the transmit low-threshold code. A write takes effect at the clock edge, and a read returns the stored value without delay.
- R2: A threshold code c selects a level in bytes. Code 0 selects 4 bytes. Any code c from 1 to 7 selects 16*c bytes, which gives 16, 32, 48, 64, 80, 96 or 112.
- R3: Bits 7:6 of the control register are ignored on a write and always read back as zero.
- R4: Register offset 1 (reg_addr=1) is the interrupt-enable register and resets to 0. Bit 0 enables the transmit-low flag and bit 1 enables the receive-high flag. Bits 7:2 are ignored on a write and read back as zero.
- R5: stat_tx_low is high exactly when the transmit count is strictly below the transmit level. The flag is registered, so it follows a count change or a control write one clock later.
- R6: stat_rx_high is high exactly when the receive count is strictly above the receive level, with the same one-clock timing as stat_tx_low.
- R7: When a count equals its selected level, the flag for that queue is low.
- R8: irq_n is low exactly when (stat_tx_low AND enable bit 0) OR (stat_rx_high AND enable bit 1) is true. irq_n responds to the flags and to the enable register without added delay.
- R9: Each queue holds 128 bytes in first-in first-out order, and its read data shows the oldest byte. The count changes at the same edge as an accepted push or pop. When a push and a pop are both accepted in one cycle, the count does not change.
- R10: A push while the count is 128 is dropped, and the overflow output pulses high for the following cycle. A pop while the count is 0 is dropped, and the underflow output pulses high for the following cycle.
- R11: After reset both queues are empty, stat_tx_low is 1, stat_rx_high is 0 and irq_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_push | input | 1 | Write strobe for the transmit queue |
| tx_wdata | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Read strobe for the transmit queue |
| tx_rdata | output | 8 | Oldest byte in the transmit queue |
| tx_level | output | 8 | Transmit occupancy in bytes |
| tx_full | output | 1 | Transmit queue holds 128 bytes |
| tx_empty | output | 1 | Transmit queue is empty |
| tx_ovf | output | 1 | Pulse: a transmit push was dropped |
| tx_udf | output | 1 | Pulse: a transmit pop was dropped |
| rx_push | input | 1 | Write strobe for the receive queue |
| rx_wdata | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Read strobe for the receive queue |
| rx_rdata | output | 8 | Oldest byte in the receive queue |
| rx_level | output | 8 | Receive occupancy in bytes |
| rx_full | output | 1 | Receive queue holds 128 bytes |
| rx_empty | output | 1 | Receive queue is empty |
| rx_ovf | output | 1 | Pulse: a receive push was dropped |
| rx_udf | output | 1 | Pulse: a receive pop was dropped |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = control, 1 = interrupt enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| stat_tx_low | output | 1 | Transmit occupancy is below its level |
| stat_rx_high | output | 1 | Receive occupancy is above its level |
| irq_n | output | 1 | Masked interrupt request, active low |

## Verification
A wrong occupancy count appears on the level port at the same edge as the push or pop that corrupted it. It appears on the matching flag one clock later, and on irq_n once that flag is enabled. A wrong stored threshold code reads back wrong at once through the register port. Its effect on the flags shows only at occupancies between the right level and the wrong one, so the bench fills the queues to each level, to one byte below it and to one byte above it. A wrong pointer is invisible in the counts and shows only as out-of-order bytes on the read data port.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

    localparam int CODE_W = 3;
    localparam int LVL_W  = 8;

    typedef struct packed {
        logic [CODE_W-1:0] tx_code;
        logic [CODE_W-1:0] rx_code;
    } wm_ctrl_t;

    // Non-linear threshold table: code 0 is a special small level, others step by 16.
    function automatic logic [LVL_W-1:0] code_to_level(input logic [CODE_W-1:0] code);
        logic [LVL_W-1:0] lvl;
        if (code == '0) lvl = LVL_W'(4);
        else            lvl = LVL_W'({code, 4'b0000});
        return lvl;
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty,
    output logic              ovf,
    output logic              udf
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             udf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push_ok, pop_ok;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        push_ok = push && (st_q.cnt != FULL_CNT);
        pop_ok  = pop  && (st_q.cnt != '0);
        st_d    = st_q;
        if (push_ok) st_d.wr = (st_q.wr == LAST_PTR) ? '0 : st_q.wr + 1'b1;
        if (pop_ok)  st_d.rd = (st_q.rd == LAST_PTR) ? '0 : st_q.rd + 1'b1;
        st_d.cnt = st_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        st_d.ovf = push && !push_ok;
        st_d.udf = pop  && !pop_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr] <= wdata;
    end

    assign rdata = mem[st_q.rd];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == FULL_CNT);
    assign empty = (st_q.cnt == '0);
    assign ovf   = st_q.ovf;
    assign udf   = st_q.udf;

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    a_r10_ovf_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> ovf);

    a_r10_full_push_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));

    a_r10_udf_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (udf && count == $past(count) + CNT_W'(!$past(full) && $past(push))));

    a_r9_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty) |=> $stable(count));

endmodule

// File: rtl/wmark_ctrl.sv
module wmark_ctrl
    import fwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    output logic             tx_low,
    output logic             rx_high,
    output logic             irq_n
);

    typedef struct packed {
        wm_ctrl_t   ctrl;
        logic [1:0] ie;
        logic       tx_low;
        logic       rx_high;
    } wm_st_t;

    wm_st_t           st_d, st_q;
    logic [CNT_W-1:0] thr_tx, thr_rx;
    logic             unused_hi;

    assign unused_hi = ^reg_wdata[7:6];

    always_comb begin
        thr_tx     = CNT_W'(code_to_level(st_q.ctrl.tx_code));
        thr_rx     = CNT_W'(code_to_level(st_q.ctrl.rx_code));
        st_d         = st_q;
        st_d.tx_low  = (tx_count < thr_tx);
        st_d.rx_high = (rx_count > thr_rx);
        if (reg_we) begin
            if (!reg_addr) begin
                st_d.ctrl.tx_code = reg_wdata[5:3];
                st_d.ctrl.rx_code = reg_wdata[2:0];
            end else begin
                st_d.ie = reg_wdata[1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.tx_low  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = reg_addr ? {6'b0, st_q.ie} : {2'b00, st_q.ctrl.tx_code, st_q.ctrl.rx_code};
    assign tx_low    = st_q.tx_low;
    assign rx_high   = st_q.rx_high;
    assign irq_n     = ~|({st_q.rx_high, st_q.tx_low} & st_q.ie);

    a_r7_tx_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == thr_tx) |=> !tx_low);

    a_r7_rx_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == thr_rx) |=> !rx_high);

    a_r5_empty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |=> tx_low);

    a_r6_empty_not_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |=> !rx_high);

    a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr && reg_wdata[1:0] == 2'b00) |=> irq_n);

    a_r3_unused_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_addr) |=> (reg_addr || reg_rdata[7:6] == 2'b00));

endmodule

// File: rtl/fifo_wmark_unit.sv
module fifo_wmark_unit #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    output logic [CNT_W-1:0]  tx_level,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              tx_ovf,
    output logic              tx_udf,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [CNT_W-1:0]  rx_level,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_ovf,
    output logic              rx_udf,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              stat_tx_low,
    output logic              stat_rx_high,
    output logic              irq_n
);

    byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .count (tx_level),
        .full  (tx_full),
        .empty (tx_empty),
        .ovf   (tx_ovf),
        .udf   (tx_udf)
    );

    byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .count (rx_level),
        .full  (rx_full),
        .empty (rx_empty),
        .ovf   (rx_ovf),
        .udf   (rx_udf)
    );

    wmark_ctrl #(.CNT_W(CNT_W)) u_wmark (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tx_count  (tx_level),
        .rx_count  (rx_level),
        .tx_low    (stat_tx_low),
        .rx_high   (stat_rx_high),
        .irq_n     (irq_n)
    );

    a_r11_irq_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> irq_n);

endmodule

// File: tb/fifo_wmark_unit_tb.sv
module fifo_wmark_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
    logic [7:0] tx_wdata = 0, rx_wdata = 0;
    logic       reg_we = 0, reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] tx_rdata, rx_rdata, tx_level, rx_level, reg_rdata;
    logic       tx_full, tx_empty, tx_ovf, tx_udf;
    logic       rx_full, rx_empty, rx_ovf, rx_udf;
    logic       stat_tx_low, stat_rx_high, irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fifo_wmark_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .tx_level(tx_level), .tx_full(tx_full), .tx_empty(tx_empty), .tx_ovf(tx_ovf), .tx_udf(tx_udf),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_level(rx_level), .rx_full(rx_full), .rx_empty(rx_empty), .rx_ovf(rx_ovf), .rx_udf(rx_udf),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stat_tx_low(stat_tx_low), .stat_rx_high(stat_rx_high), .irq_n(irq_n)
    );

    // {tx_code[2:0], rx_code[2:0], fill[7:0]}
    localparam logic [13:0] VEC [12] = '{
        {3'd0, 3'd0, 8'd0},   {3'd0, 3'd0, 8'd4},   {3'd0, 3'd0, 8'd5},
        {3'd1, 3'd1, 8'd15},  {3'd1, 3'd1, 8'd16},  {3'd1, 3'd1, 8'd17},
        {3'd3, 3'd2, 8'd33},  {3'd7, 3'd7, 8'd112}, {3'd7, 3'd7, 8'd113},
        {3'd4, 3'd5, 8'd80},  {3'd6, 3'd6, 8'd128}, {3'd2, 3'd4, 8'd64}
    };

    function automatic int lvl_of(input logic [2:0] c);
        return (c == 0) ? 4 : 16 * int'(c);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 0; reg_addr = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 130; i++) begin
            tx_pop = (tx_level != 0);
            rx_pop = (rx_level != 0);
            tick();
        end
        tx_pop = 0; rx_pop = 0;
        tick();
    endtask

    task automatic fill_both(input int n);
        for (int i = 0; i < n; i++) begin
            tx_push = 1; rx_push = 1;
            tx_wdata = 8'(i); rx_wdata = 8'(i + 1);
            tick();
        end
        tx_push = 0; rx_push = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();

        // R11 reset state, R1 control reset value
        check("R11", "tx_level", tx_level, 0);
        check("R11", "rx_empty", rx_empty, 1);
        check("R11", "stat_tx_low", stat_tx_low, 1);
        check("R11", "stat_rx_high", stat_rx_high, 0);
        check("R11", "irq_n", irq_n, 1);
        reg_addr = 0; #1;
        check("R1", "ctrl reset", reg_rdata, 8'h00);

        // R2 R5 R6 R7: vector table walk
        foreach (VEC[k]) begin
            logic [2:0] tc, rc;
            int fill;
            tc = VEC[k][13:11]; rc = VEC[k][10:8]; fill = int'(VEC[k][7:0]);
            drain();
            wr_reg(1'b0, {2'b00, tc, rc});
            fill_both(fill);
            tick(); tick();
            check("R9", "tx_level", tx_level, fill);
            check("R2/R5 tx_low", "stat_tx_low", stat_tx_low, (fill < lvl_of(tc)) ? 1 : 0);
            check("R2/R6 rx_high", "stat_rx_high", stat_rx_high, (fill > lvl_of(rc)) ? 1 : 0);
            if (fill == lvl_of(tc)) check("R7", "tx flag at level", stat_tx_low, 0);
        end

        // R3 unused control bits
        wr_reg(1'b0, 8'hFF);
        reg_addr = 0; #1;
        check("R3", "ctrl readback", reg_rdata, 8'h3F);
        wr_reg(1'b0, 8'hC0);
        reg_addr = 0; #1;
        check("R3", "ctrl high bits ignored", reg_rdata, 8'h00);

        // R4 enable register
        reg_addr = 1; #1;
        check("R4", "ie reset", reg_rdata, 8'h00);
        wr_reg(1'b1, 8'hFF);
        reg_addr = 1; #1;
        check("R4", "ie readback", reg_rdata, 8'h03);
        reg_addr = 0;

        // R5 timing: flag lags count by one clock
        drain();
        wr_reg(1'b1, 8'h00);
        for (int i = 0; i < 3; i++) begin tx_push = 1; tx_wdata = 8'h10; tick(); end
        tx_push = 0; tick();
        check("R5", "tx_low at 3", stat_tx_low, 1);
        tx_push = 1; tick(); tx_push = 0;
        check("R5", "level 4", tx_level, 4);
        check("R5", "flag still old", stat_tx_low, 1);
        tick();
        check("R5", "flag after one clock", stat_tx_low, 0);

        // R8 interrupt masking
        drain();
        wr_reg(1'b1, 8'h00);
        check("R8", "irq masked", irq_n, 1);
        wr_reg(1'b1, 8'h01);
        check("R8", "irq tx_low enabled", irq_n, 0);
        wr_reg(1'b1, 8'h02);
        check("R8", "irq rx only, rx not high", irq_n, 1);
        for (int i = 0; i < 5; i++) begin rx_push = 1; rx_wdata = 8'h20; tick(); end
        rx_push = 0; tick();
        check("R8", "irq rx_high enabled", irq_n, 0);
        wr_reg(1'b1, 8'h00);
        check("R8", "irq masked again", irq_n, 1);

        // R9 ordering and simultaneous push/pop
        drain();
        tx_push = 1; tx_wdata = 8'hA1; tick();
        tx_wdata = 8'hB2; tick();
        tx_wdata = 8'hC3; tick();
        tx_push = 0;
        check("R9", "head byte", tx_rdata, 8'hA1);
        tx_pop = 1; tick(); tx_pop = 0;
        check("R9", "second byte", tx_rdata, 8'hB2);
        tx_push = 1; tx_pop = 1; tx_wdata = 8'hD4; tick();
        tx_push = 0; tx_pop = 0;
        check("R9", "level after push+pop", tx_level, 2);
        check("R9", "head after push+pop", tx_rdata, 8'hC3);
        tx_pop = 1; tick(); tx_pop = 0;
        check("R9", "last byte", tx_rdata, 8'hD4);

        // R10 overflow and underflow
        drain();
        for (int i = 0; i < 128; i++) begin rx_push = 1; rx_wdata = 8'(i); tick(); end
        check("R10", "rx_full", rx_full, 1);
        check("R10", "no ovf yet", rx_ovf, 0);
        rx_wdata = 8'hEE; tick(); rx_push = 0;
        check("R10", "ovf pulse", rx_ovf, 1);
        check("R10", "level held", rx_level, 128);
        tick();
        check("R10", "ovf one cycle", rx_ovf, 0);
        check("R10", "head untouched", rx_rdata, 8'h00);
        tx_pop = 1; tick(); tx_pop = 0;
        check("R10", "udf pulse", tx_udf, 1);
        check("R10", "level stays 0", tx_level, 0);
        tick();
        check("R10", "udf one cycle", tx_udf, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule